// File: doc/BRIEF.md
# Synchronous Serial Transmit Framer

This block drives the transmit data line of a synchronous serial port. It advances only on bit-clock enable ticks. When a start strobe is seen on a tick while no frame is running, it begins a frame. The frame opens with an optional tag taken from a sync word. Then it sends a configured number of data words, each of a configured length, in a configured bit order, starting a configured number of bit periods after the start tick. Outside a frame the line sits at a programmable idle level.

Data words come in through a one-entry holding stage with a valid/ready handshake. A word is taken from the holding stage on the tick that sends its first bit. If no word is held at that moment, the word slot is filled with the idle level and a sticky underrun flag is raised.

Fields are encoded as value-minus-one: tag length is `sync_len`+1, word length is `word_len`+1, and words per frame is `word_cnt`+1. The start delay `delay` is an exact count of bit periods. Configuration is expected to stay unchanged while a frame runs.

Top module: `sync_tx_framer`

## Requirements
- R1: While reset is asserted, `txd` is 0, `tx_ready` is 1 and `underrun` is 0.
- R2: `txd` changes only in the cycle after a cycle with `bit_en` high. On a tick with no frame running and no start, `txd` takes the value of `idle_level`.
- R3: A frame starts only on a tick (`start` and `bit_en` both high) while no frame is running. The start tick drives frame bit 0, and each later tick drives the next frame bit. A start seen while a frame runs has no effect, and this shows on `txd`.
- R4: The first data bit is frame bit `delay`. With `delay` = 0 it is driven on the start tick itself. Frame bits before `delay` that carry no tag are at the idle level.
- R5: A frame carries `word_cnt`+1 words of `word_len`+1 bits each, back to back with no gap. The tick after the last bit returns the line to the idle level.
- R6: With `msb_first`=1, each word is sent from bit `word_len` down to bit 0. With `msb_first`=0, it is sent from bit 0 up.
- R7: When `sync_en`=1 and `sync_len`+1 ≤ `delay`, frame bits 0..`sync_len` carry `sync_word` bits 0..`sync_len`, in the same order rule as data. With `msb_first`=1, bit `sync_len` goes first.
- R8: When `sync_en`=0, or when `sync_len`+1 > `delay`, no tag is sent. Bits before `delay` stay at the idle level and data timing is unchanged.
- R9: `tx_ready` is high exactly when the holding stage is empty. A word is accepted on a clock with `tx_valid` and `tx_ready` both high. The held word is consumed on the tick that sends a word's first bit.
- R10: If the holding stage is empty on a word's first-bit tick, that whole word is sent at the idle level. `underrun` then rises and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Bit-clock enable tick |
| start | input | 1 | Frame start request |
| sync_en | input | 1 | Send a tag ahead of the data |
| sync_len | input | $clog2(SW) | Tag length minus one |
| delay | input | DLY_W | Bit periods from start to first data bit |
| word_len | input | $clog2(DW) | Word length minus one |
| word_cnt | input | CNT_W | Words per frame minus one |
| msb_first | input | 1 | 1: most significant bit first |
| idle_level | input | 1 | Line level outside tag and data |
| sync_word | input | SW | Tag source |
| tx_data | input | DW | Data word |
| tx_valid | input | 1 | Data word valid |
| tx_ready | output | 1 | Holding stage empty |
| txd | output | 1 | Serial data line |
| underrun | output | 1 | Sticky underrun flag |

## Verification
A wrong frame position or word-bit counter shows on `txd` at the next tick. It shifts the tag, gap or data by one bit, or lets a frame end early or run past its last word. A lost or doubled holding-stage state shows within a cycle on `tx_ready`. It also shows at the next word boundary as a wrong word or a false underrun. Because the bench compares every cycle, a single wrong bit is reported in the cycle it appears.

// File: rtl/sync_tx_framer.sv
module sync_tx_framer #(
  parameter int DW    = 32,
  parameter int SW    = 16,
  parameter int DLY_W = 8,
  parameter int CNT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_en,
  input  logic                   start,
  input  logic                   sync_en,
  input  logic [$clog2(SW)-1:0]  sync_len,
  input  logic [DLY_W-1:0]       delay,
  input  logic [$clog2(DW)-1:0]  word_len,
  input  logic [CNT_W-1:0]       word_cnt,
  input  logic                   msb_first,
  input  logic                   idle_level,
  input  logic [SW-1:0]          sync_word,
  input  logic [DW-1:0]          tx_data,
  input  logic                   tx_valid,
  output logic                   tx_ready,
  output logic                   txd,
  output logic                   underrun
);
  localparam int SLW = $clog2(SW);
  localparam int WLW = $clog2(DW);

  logic             active, sync_go, hold_full, txd_r, urun_r;
  logic [DLY_W-1:0] pos;
  logic [WLW-1:0]   bidx;
  logic [CNT_W-1:0] widx;
  logic [DW-1:0]    cur, hold;

  wire              run      = bit_en & (active | start);
  wire  [DLY_W-1:0] p        = active ? pos : '0;
  wire              in_data  = p >= delay;
  wire              sync_ok  = sync_en & (DLY_W'(sync_len) < delay);
  wire              sync_on  = active ? sync_go : sync_ok;
  wire              in_sync  = sync_on & (p <= DLY_W'(sync_len));
  wire              first    = (bidx == '0);
  wire              last_bit = (bidx == word_len);
  wire              last_wd  = (widx == word_cnt);
  wire  [DW-1:0]    wsrc     = first ? (hold_full ? hold : {DW{idle_level}}) : cur;
  wire  [SLW-1:0]   sp       = p[SLW-1:0];
  wire              data_bit = msb_first ? wsrc[word_len - bidx] : wsrc[bidx];
  wire              sync_bit = msb_first ? sync_word[sync_len - sp] : sync_word[sp];
  wire              nbit     = in_data ? data_bit : (in_sync ? sync_bit : idle_level);

  assign tx_ready = ~hold_full;
  assign txd      = txd_r;
  assign underrun = urun_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      sync_go   <= 1'b0;
      hold_full <= 1'b0;
      txd_r     <= 1'b0;
      urun_r    <= 1'b0;
      pos       <= '0;
      bidx      <= '0;
      widx      <= '0;
      cur       <= '0;
      hold      <= '0;
    end else begin
      if (tx_valid && !hold_full) begin
        hold      <= tx_data;
        hold_full <= 1'b1;
      end
      if (run) begin
        txd_r <= nbit;
        if (!active) begin
          active  <= 1'b1;
          sync_go <= sync_ok;
        end
        pos <= in_data ? p : p + 1'b1;
        if (in_data) begin
          if (first) begin
            cur <= wsrc;
            if (hold_full) hold_full <= 1'b0;
            else           urun_r    <= 1'b1;
          end
          if (last_bit) begin
            bidx <= '0;
            if (last_wd) begin
              widx   <= '0;
              pos    <= '0;
              active <= 1'b0;
            end else begin
              widx <= widx + 1'b1;
            end
          end else begin
            bidx <= bidx + 1'b1;
          end
        end
      end else if (bit_en) begin
        txd_r <= idle_level;
      end
    end
  end
endmodule

// File: rtl/sync_tx_framer_chk.sv
module sync_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic start,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd,
  input logic underrun,
  input logic idle_level,
  input logic active
);
  AST_TXD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(txd)); // R2

  AST_IDLE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && !active && !start |=> txd == $past(idle_level)); // R2

  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready); // R9

  AST_DRAIN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready && !bit_en |=> !tx_ready); // R9

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun); // R10

  AST_UNDERRUN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(bit_en) && $past(active || start)); // R10
endmodule

bind sync_tx_framer sync_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
  .underrun(underrun), .idle_level(idle_level), .active(active)
);

// File: tb/sync_tx_framer_test.sv
module sync_tx_framer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0, start = 1'b0, sync_en = 1'b0;
  logic [3:0]  sync_len = '0;
  logic [7:0]  delay = '0;
  logic [4:0]  word_len = '0;
  logic [3:0]  word_cnt = '0;
  logic        msb_first = 1'b1, idle_level = 1'b0;
  logic [15:0] sync_word = '0;
  logic [31:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, txd, underrun;

  sync_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
    .sync_en(sync_en), .sync_len(sync_len), .delay(delay),
    .word_len(word_len), .word_cnt(word_cnt), .msb_first(msb_first),
    .idle_level(idle_level), .sync_word(sync_word), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .underrun(underrun)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int div = 1;
  bit feed_en = 1'b1;
  bit armed = 1'b0;
  logic [31:0] feed[$];

  // reference model state
  bit          m_act, m_sy, m_hn, m_und, m_ui, m_txd;
  logic [31:0] m_h, m_wd;
  int          fb;
  string       m_tag = "R1";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_hn = 0; m_und = 0; m_txd = 0; m_ui = 0; fb = 0; m_tag = "R1";
    end else begin
      bit acc, ign, b_out;
      string tag;
      int w_len, n_wd, off, b, w;
      acc = tx_valid && !m_hn;
      if (bit_en) begin
        w_len = int'(word_len) + 1;
        n_wd  = int'(word_cnt) + 1;
        ign   = m_act && start;
        b_out = idle_level;
        tag   = "R2";
        if (m_act || start) begin
          if (!m_act) begin
            m_act = 1; fb = 0;
            m_sy = sync_en && (int'(sync_len) + 1 <= int'(delay));
          end
          if (fb >= int'(delay)) begin
            off = fb - int'(delay);
            b = off % w_len;
            w = off / w_len;
            if (b == 0) begin
              if (m_hn) begin m_wd = m_h; m_hn = 0; m_ui = 0; end
              else begin m_ui = 1; m_und = 1; end
              tag = (w == 0) ? "R4" : "R5";
            end else tag = "R6";
            if (m_ui) begin b_out = idle_level; tag = "R10"; end
            else b_out = msb_first ? m_wd[w_len-1-b] : m_wd[b];
            if (b == w_len-1 && w == n_wd-1) m_act = 0;
          end else if (m_sy && fb <= int'(sync_len)) begin
            b_out = msb_first ? sync_word[int'(sync_len)-fb] : sync_word[fb];
            tag = "R7";
          end else begin
            tag = (sync_en && !m_sy) ? "R8" : "R4";
          end
          fb++;
        end
        if (ign) tag = "R3";
        m_txd = b_out;
        m_tag = tag;
      end
      if (acc) begin
        m_h = tx_data; m_hn = 1;
        void'(feed.pop_front());
      end
    end
  end

  task automatic check(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  initial begin
    @(posedge clk);
    armed = 1'b1;
  end

  initial forever begin
    @(negedge clk);
    tx_valid = feed_en && feed.size() > 0;
    tx_data  = (feed.size() > 0) ? feed[0] : '0;
    if (armed) begin
      check(rst_n ? m_tag : "R1", "txd", txd, rst_n ? m_txd : 1'b0);
      check(rst_n ? "R9" : "R1", "tx_ready", tx_ready, rst_n ? !m_hn : 1'b1);
      check(rst_n ? "R10" : "R1", "underrun", underrun, rst_n ? m_und : 1'b0);
    end
  end

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      bit_en = (cnt == 0);
      cnt = (cnt + 1) % div;
    end
  end

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    do @(posedge clk); while (!bit_en);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int extra);
    @(negedge clk);
    while (m_act) @(negedge clk);
    repeat (extra) @(negedge clk);
  endtask

  task automatic cfg(input bit se, input int sl, input int dl, input int wl,
                     input int wc, input bit mf, input bit il);
    sync_en = se; sync_len = 4'(sl); delay = 8'(dl);
    word_len = 5'(wl); word_cnt = 4'(wc); msb_first = mf; idle_level = il;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2: idle level follows the input
    idle_level = 1'b1; repeat (6) @(negedge clk);
    idle_level = 1'b0; repeat (6) @(negedge clk);

    // R4 R5 R6: msb first, no tag, every cycle a tick
    sync_word = 16'hA5C3;
    feed.push_back(32'h0000_00B6); feed.push_back(32'h0000_0039);
    cfg(0, 3, 3, 7, 1, 1, 1);
    do_start(); wait_done(4);

    // R7 R6: tag then lsb first words, tick every 3 cycles
    div = 3;
    feed.push_back(32'h15); feed.push_back(32'h0A); feed.push_back(32'h1C);
    cfg(1, 3, 6, 4, 2, 0, 0);
    do_start(); wait_done(8);

    // R7 msb first tag, long words
    div = 2;
    sync_word = 16'h9E37;
    feed.push_back(32'hDEAD_BEEF); feed.push_back(32'h1234_5678);
    cfg(1, 15, 20, 31, 1, 1, 1);
    do_start(); wait_done(6);

    // R8: tag longer than delay is dropped
    div = 1;
    feed.push_back(32'h5); feed.push_back(32'h3);
    cfg(1, 4, 3, 2, 1, 1, 1);
    do_start(); wait_done(4);

    // R4: zero delay, single one-bit word
    feed.push_back(32'h1);
    cfg(0, 0, 0, 0, 0, 1, 0);
    do_start(); wait_done(4);

    // R3: start held mid-frame is ignored, then back-to-back frames
    div = 2;
    repeat (4) feed.push_back(32'hC3);
    cfg(0, 0, 2, 7, 1, 0, 0);
    do_start();
    repeat (6) @(negedge clk);
    start = 1'b1;
    repeat (8) @(negedge clk);
    start = 1'b0;
    wait_done(6);
    start = 1'b1;
    do @(negedge clk); while (!m_act);
    @(negedge clk); start = 1'b0;
    while (m_act) @(negedge clk);
    start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    wait_done(6);

    // R10: underrun on every word, then a partial supply
    div = 1;
    feed.delete();
    feed_en = 1'b0;
    cfg(0, 0, 1, 3, 1, 1, 1);
    do_start(); wait_done(3);
    feed_en = 1'b1;
    feed.push_back(32'h6);
    cfg(0, 0, 1, 3, 1, 1, 0);
    do_start(); wait_done(6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule